// File: doc/BRIEF.md
# Byte-Memory Boot Loader

This block fills internal program memory from an external byte-wide memory. Every program word is 24 bits wide and is gathered from three consecutive external bytes, the most significant byte first. Once the whole word is present, it is written into internal memory in one cycle. Each external read is stretched by a programmable number of wait cycles. The external byte address is the concatenation of an 8-bit page and a 14-bit byte address.

When reset is released, the block presets itself for a 32-word boot and starts copying at once. While that copy runs, the processor is held. Software can start further copies later: it programs the registers and then writes a nonzero word count. A context-reset control bit decides what happens at the end of a copy. When the bit is set, the processor is held for the whole copy, and when the copy ends a restart at program address zero is requested. Every finished copy leaves a completion interrupt pending until it is acknowledged.

Top module: `byteBootLoader`

## Requirements
- R1: After reset, the registers read as follows: word count (offset 0) 32, internal address (offset 1) 0, external address (offset 2) 0, page (offset 3) 0, wait states (offset 4) 7, control (offset 5) 1. The control register holds bit0 context reset, bit1 word type and bit2 direction. The block is busy, and the boot copy starts without any software action.
- R2: Each internal write lasts a single cycle with `pmWe` high. It carries the three most recent bytes in read order, the first byte in `pmData[23:16]`, and it goes to the current internal address.
- R3: `memAddr` is {page, external address}. The external address advances by 1 per byte and the internal address by 1 per word. After the 32-word boot they read 0x60 and 0x20.
- R4: Each byte read keeps `memRd` high on one address for wait+1 cycles. `memRd` is low in the internal-write cycle. A word therefore takes 3*(wait+1)+1 cycles.
- R5: A write of a nonzero value to offset 0 while idle starts a copy, and `busy` is high in the next cycle. A write of zero starts nothing.
- R6: The word count drops by 1 per written word and reads 0 at the end. It can be read while a copy runs.
- R7: `busy` stays high from the start write until the last word is written. Register writes made while busy change nothing.
- R8: `cpuHold` equals `busy` when context reset is 1, and stays low when it is 0.
- R9: When a copy finishes with context reset 1, `restartAtZero` is high for exactly the one cycle after the last write. With context reset 0 it stays low.
- R10: `doneIrq` rises together with the fall of `busy`. It stays high until `irqAck` is seen. If completion and acknowledge arrive in the same cycle, the completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; release starts the boot copy |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for reads and writes |
| regWData | input | 16 | Register write data |
| irqAck | input | 1 | Clears the pending completion interrupt |
| regRData | output | 16 | Register read data for `regAddr` (combinational) |
| memAddr | output | 22 | External byte address {page, address} |
| memRd | output | 1 | External byte read strobe |
| memData | input | 8 | External byte read data, sampled in the last cycle of a read |
| pmWe | output | 1 | Internal program-memory write enable |
| pmAddr | output | 14 | Internal program-memory address |
| pmData | output | 24 | Assembled program word |
| cpuHold | output | 1 | Holds processor execution |
| restartAtZero | output | 1 | One-cycle request to restart at program address zero |
| doneIrq | output | 1 | Pending completion interrupt |
| busy | output | 1 | Copy in progress |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that `irqAck` is the only way the pending interrupt is cleared, so a pending flag may only drop in a cycle after an acknowledge. They take the external memory to answer combinationally, so that the byte on `memData` in the last read cycle belongs to `memAddr`. The stimulus keeps to all of this: it models the memory as a pure function of the address, pulses `irqAck` only while idle, and chooses start addresses low enough that no copy wraps the 14-bit external or internal address.

// File: rtl/bootDmaPkg.sv
package bootDmaPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic busy;
    logic start;
    logic byteDone;
    logic wordWrite;
    logic finish;
  } dmaStrobes_t;

  localparam logic [2:0] REG_COUNT = 3'd0;
  localparam logic [2:0] REG_INT   = 3'd1;
  localparam logic [2:0] REG_EXT   = 3'd2;
  localparam logic [2:0] REG_PAGE  = 3'd3;
  localparam logic [2:0] REG_WAIT  = 3'd4;
  localparam logic [2:0] REG_CTRL  = 3'd5;

endpackage

// File: rtl/bootDmaCtrl.sv
module bootDmaCtrl
  import bootDmaPkg::*;
#(
  parameter int WAIT_W = 3,
  parameter int BYTES  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [WAIT_W-1:0] waitStates,
  input  logic              lastWord,
  output dmaStrobes_t       strb
);

  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  dmaState_e         state;
  logic [WAIT_W-1:0] waitCtr;
  logic [IDX_W-1:0]  byteIdx;

  always_comb begin
    strb.busy      = (state != ST_IDLE);
    strb.start     = startReq && (state == ST_IDLE);
    strb.byteDone  = (state == ST_READ) && (waitCtr == waitStates);
    strb.wordWrite = (state == ST_WRITE);
    strb.finish    = (state == ST_WRITE) && lastWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_READ;   // boot copy begins on reset release
      waitCtr <= '0;
      byteIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.start) begin
            state   <= ST_READ;
            waitCtr <= '0;
            byteIdx <= '0;
          end
        end
        ST_READ: begin
          if (strb.byteDone) begin
            waitCtr <= '0;
            if (byteIdx == LAST_IDX) begin
              byteIdx <= '0;
              state   <= ST_WRITE;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end else begin
            waitCtr <= waitCtr + 1'b1;
          end
        end
        ST_WRITE: state <= lastWord ? ST_IDLE : ST_READ;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bootDmaPath.sv
module bootDmaPath
  import bootDmaPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int INT_AW     = 14,
  parameter int EXT_AW     = 14,
  parameter int PAGE_W     = 8,
  parameter int WAIT_W     = 3,
  parameter int CNT_W      = 16,
  parameter int BYTES      = 3,
  parameter int BOOT_WORDS = 32,
  parameter int BOOT_WAIT  = 7,
  localparam int WORD_W    = 8 * BYTES,
  localparam int MEM_AW    = PAGE_W + EXT_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobes_t       strb,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWData,
  input  logic [7:0]        memData,
  input  logic              irqAck,
  output logic [DATA_W-1:0] regRData,
  output logic [MEM_AW-1:0] memAddr,
  output logic              startReq,
  output logic [WAIT_W-1:0] waitStates,
  output logic              lastWord,
  output logic [INT_AW-1:0] pmAddr,
  output logic [WORD_W-1:0] pmData,
  output logic              cpuHold,
  output logic              restartAtZero,
  output logic              doneIrq
);

  logic [INT_AW-1:0] intAddr;
  logic [EXT_AW-1:0] extAddr;
  logic [PAGE_W-1:0] page;
  logic [CNT_W-1:0]  wordCount;
  logic [2:0]        ctrlBits;   // {direction, wordType, ctxReset}
  logic [WORD_W-1:0] assembly;
  logic              cfgWe;

  assign cfgWe    = regWe && !strb.busy;
  assign startReq = cfgWe && (regAddr == REG_COUNT) && (|regWData[CNT_W-1:0]);
  assign lastWord = (wordCount == CNT_W'(1));
  assign memAddr  = {page, extAddr};
  assign pmAddr   = intAddr;
  assign pmData   = assembly;
  assign cpuHold  = strb.busy && ctrlBits[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intAddr    <= '0;
      extAddr    <= '0;
      page       <= '0;
      wordCount  <= CNT_W'(BOOT_WORDS);
      waitStates <= WAIT_W'(BOOT_WAIT);
      ctrlBits   <= 3'b001;
    end else if (cfgWe) begin
      unique case (regAddr)
        REG_COUNT: wordCount  <= regWData[CNT_W-1:0];
        REG_INT:   intAddr    <= regWData[INT_AW-1:0];
        REG_EXT:   extAddr    <= regWData[EXT_AW-1:0];
        REG_PAGE:  page       <= regWData[PAGE_W-1:0];
        REG_WAIT:  waitStates <= regWData[WAIT_W-1:0];
        REG_CTRL:  ctrlBits   <= regWData[2:0];
        default:   ;
      endcase
    end else begin
      if (strb.byteDone)  extAddr <= extAddr + 1'b1;
      if (strb.wordWrite) begin
        intAddr   <= intAddr + 1'b1;
        wordCount <= wordCount - 1'b1;
      end
    end
  end

  // byte assembly, first byte ends up most significant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               assembly <= '0;
    else if (strb.byteDone)  assembly <= {assembly[WORD_W-9:0], memData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      restartAtZero <= 1'b0;
      doneIrq       <= 1'b0;
    end else begin
      restartAtZero <= strb.finish && ctrlBits[0];
      if (strb.finish)  doneIrq <= 1'b1;
      else if (irqAck)  doneIrq <= 1'b0;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_COUNT: regRData = DATA_W'(wordCount);
      REG_INT:   regRData = DATA_W'(intAddr);
      REG_EXT:   regRData = DATA_W'(extAddr);
      REG_PAGE:  regRData = DATA_W'(page);
      REG_WAIT:  regRData = DATA_W'(waitStates);
      REG_CTRL:  regRData = DATA_W'(ctrlBits);
      default:   regRData = '0;
    endcase
  end

endmodule

// File: rtl/byteBootLoader.sv
module byteBootLoader
  import bootDmaPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int INT_AW     = 14,
  parameter int EXT_AW     = 14,
  parameter int PAGE_W     = 8,
  parameter int WAIT_W     = 3,
  parameter int CNT_W      = 16,
  parameter int BYTES      = 3,
  parameter int BOOT_WORDS = 32,
  parameter int BOOT_WAIT  = 7,
  localparam int WORD_W    = 8 * BYTES,
  localparam int MEM_AW    = PAGE_W + EXT_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWData,
  input  logic              irqAck,
  output logic [DATA_W-1:0] regRData,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memRd,
  input  logic [7:0]        memData,
  output logic              pmWe,
  output logic [INT_AW-1:0] pmAddr,
  output logic [WORD_W-1:0] pmData,
  output logic              cpuHold,
  output logic              restartAtZero,
  output logic              doneIrq,
  output logic              busy
);

  dmaStrobes_t       strb;
  logic              startReq;
  logic              lastWord;
  logic [WAIT_W-1:0] waitStates;

  bootDmaCtrl #(.WAIT_W(WAIT_W), .BYTES(BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .waitStates(waitStates),
    .lastWord(lastWord), .strb(strb)
  );

  bootDmaPath #(
    .DATA_W(DATA_W), .INT_AW(INT_AW), .EXT_AW(EXT_AW), .PAGE_W(PAGE_W),
    .WAIT_W(WAIT_W), .CNT_W(CNT_W), .BYTES(BYTES),
    .BOOT_WORDS(BOOT_WORDS), .BOOT_WAIT(BOOT_WAIT)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWe(regWe), .regAddr(regAddr),
    .regWData(regWData), .memData(memData), .irqAck(irqAck),
    .regRData(regRData), .memAddr(memAddr), .startReq(startReq),
    .waitStates(waitStates), .lastWord(lastWord), .pmAddr(pmAddr),
    .pmData(pmData), .cpuHold(cpuHold), .restartAtZero(restartAtZero),
    .doneIrq(doneIrq)
  );

  assign busy  = strb.busy;
  assign pmWe  = strb.wordWrite;
  assign memRd = strb.busy && !strb.wordWrite;

endmodule

// File: rtl/bootDmaChecker.sv
module bootDmaChecker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic cpuHold,
  input logic memRd,
  input logic pmWe,
  input logic restartAtZero,
  input logic doneIrq,
  input logic irqAck
);

  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cpuHold |-> busy);                                           // R8

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    pmWe |=> !pmWe);                                             // R2

  AST_NO_READ_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    pmWe |-> (!memRd && busy));                                  // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRd && !pmWe));                                // R7

  AST_RESTART_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    restartAtZero |-> (!busy && $past(busy) && doneIrq));        // R9

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && !irqAck) |=> doneIrq);                           // R10

  AST_IRQ_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> $fell(busy));                             // R10

endmodule

bind byteBootLoader bootDmaChecker uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .cpuHold(cpuHold), .memRd(memRd),
  .pmWe(pmWe), .restartAtZero(restartAtZero), .doneIrq(doneIrq),
  .irqAck(irqAck)
);

// File: tb/sim_byteBootLoader.sv
`timescale 1ns/100ps
module sim_byteBootLoader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWData = 16'd0;
  logic        irqAck = 1'b0;
  logic [15:0] regRData;
  logic [21:0] memAddr;
  logic        memRd;
  logic [7:0]  memData;
  logic        pmWe;
  logic [13:0] pmAddr;
  logic [23:0] pmData;
  logic        cpuHold, restartAtZero, doneIrq, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int busyCycles = 0;
  int pmWrites = 0;

  // expectation state shared with the monitor
  logic [7:0]  expPage = 8'd0;
  logic [13:0] expExt = 14'd0;
  logic [13:0] expInt = 14'd0;
  int          expW = 7;

  always #5 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [21:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  assign memData = memByte(memAddr);

  byteBootLoader u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWData(regWData), .irqAck(irqAck), .regRData(regRData),
    .memAddr(memAddr), .memRd(memRd), .memData(memData), .pmWe(pmWe),
    .pmAddr(pmAddr), .pmData(pmData), .cpuHold(cpuHold),
    .restartAtZero(restartAtZero), .doneIrq(doneIrq), .busy(busy)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // watchdog
  always @(negedge clk) begin
    cycles++;
    if (rstN && busy) busyCycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // bus monitor: read-window lengths, byte addresses, assembled words
  int          runLen = 0;
  logic        runActive = 1'b0;
  logic [21:0] lastAddr = '0;
  logic [23:0] hist = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memRd && runActive && memAddr == lastAddr) begin
        runLen++;
      end else begin
        if (runActive)
          check(runLen == expW + 1, "R4 read window", runLen, expW + 1);
        runActive = 1'b0;
        if (memRd) begin
          check(memAddr == {expPage, expExt}, "R3 byte address", memAddr, {expPage, expExt});
          expExt = expExt + 1'b1;
          hist = {hist[15:0], memByte(memAddr)};
          runActive = 1'b1;
          runLen = 1;
          lastAddr = memAddr;
        end
      end
      if (pmWe) begin
        pmWrites++;
        check(pmData == hist, "R2 word data", pmData, hist);
        check(pmAddr == expInt, "R2 word address", pmAddr, expInt);
        expInt = expInt + 1'b1;
      end
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #0.2;
    d = regRData;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic ackIrq();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    check(doneIrq == 1'b0, "R10 ack clears", doneIrq, 0);
  endtask

  task automatic runTransfer(input logic [7:0] pg, input logic [13:0] ex,
                             input logic [13:0] ia, input int w,
                             input logic ctx, input int cnt);
    logic [15:0] rd;
    writeReg(3'd3, {8'd0, pg});
    writeReg(3'd2, {2'b00, ex});
    writeReg(3'd1, {2'b00, ia});
    writeReg(3'd4, 16'(w));
    writeReg(3'd5, {15'd0, ctx});
    if (doneIrq) ackIrq();
    expPage = pg; expExt = ex; expInt = ia; expW = w;
    @(negedge clk);
    busyCycles = 0;
    writeReg(3'd0, 16'(cnt));
    check(busy == 1'b1, "R5 start", busy, 1);
    check(cpuHold == ctx, "R8 hold follows ctx", cpuHold, ctx);
    readReg(3'd0, rd);
    check(rd >= 1 && rd <= 16'(cnt), "R6 count readable", rd, cnt);
    waitIdle();
    check(busyCycles == cnt * (3 * (w + 1) + 1), "R7 busy length", busyCycles, cnt * (3 * (w + 1) + 1));
    check(restartAtZero == ctx, "R9 restart pulse", restartAtZero, ctx);
    check(doneIrq == 1'b1, "R10 irq pending", doneIrq, 1);
    check(cpuHold == 1'b0, "R8 hold released", cpuHold, 0);
    readReg(3'd1, rd);
    check(rd == 16'(ia + 14'(cnt)), "R3 final internal", rd, ia + 14'(cnt));
    readReg(3'd2, rd);
    check(rd == 16'(ex + 14'(3 * cnt)), "R3 final external", rd, ex + 14'(3 * cnt));
    readReg(3'd0, rd);
    check(rd == 16'd0, "R6 count ends zero", rd, 0);
    @(negedge clk);
    check(restartAtZero == 1'b0, "R9 pulse one cycle", restartAtZero, 0);
  endtask

  initial begin
    logic [15:0] rd;
    int w0;
    void'($urandom(32'hB007));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset preset state
    check(busy == 1'b1, "R1 busy at boot", busy, 1);
    check(cpuHold == 1'b1, "R1 hold at boot", cpuHold, 1);
    check(doneIrq == 1'b0, "R1 irq clear", doneIrq, 0);
    readReg(3'd0, rd); check(rd == 16'd32, "R1 count", rd, 32);
    readReg(3'd1, rd); check(rd == 16'd0, "R1 internal", rd, 0);
    readReg(3'd3, rd); check(rd == 16'd0, "R1 page", rd, 0);
    readReg(3'd4, rd); check(rd == 16'd7, "R1 wait", rd, 7);
    readReg(3'd5, rd); check(rd == 16'd1, "R1 control", rd, 1);
    // R7: writes during the boot copy are ignored
    writeReg(3'd1, 16'h0155);
    writeReg(3'd3, 16'h00AA);
    repeat (60) @(negedge clk);
    readReg(3'd0, rd);
    check(rd > 0 && rd < 32, "R6 count mid-boot", rd, 16);
    waitIdle();
    check(busyCycles == 32 * 25, "R4 boot length", busyCycles, 800);
    check(restartAtZero == 1'b1, "R9 boot restart", restartAtZero, 1);
    check(doneIrq == 1'b1, "R10 boot irq", doneIrq, 1);
    check(pmWrites == 32, "R3 boot words", pmWrites, 32);
    readReg(3'd1, rd); check(rd == 16'h0020, "R3 boot internal end", rd, 32'h20);
    readReg(3'd2, rd); check(rd == 16'h0060, "R3 boot external end", rd, 32'h60);
    readReg(3'd3, rd); check(rd == 16'h0000, "R7 page untouched", rd, 0);
    readReg(3'd0, rd); check(rd == 16'd0, "R6 boot count zero", rd, 0);
    // R10: stays pending until acknowledged
    repeat (5) @(negedge clk);
    check(doneIrq == 1'b1, "R10 irq held", doneIrq, 1);
    ackIrq();
    // R5: zero count starts nothing
    w0 = pmWrites;
    writeReg(3'd0, 16'd0);
    repeat (8) @(negedge clk);
    check(busy == 1'b0, "R5 zero count idle", busy, 0);
    check(pmWrites == w0, "R5 zero count no write", pmWrites, w0);
    // directed corners
    runTransfer(8'hFF, 14'h0000, 14'h0100, 0, 1'b0, 1);
    runTransfer(8'h01, 14'h1234, 14'h0ABC, 7, 1'b1, 2);
    // constrained random
    for (int i = 0; i < 8; i++) begin
      runTransfer(8'($urandom % 256), 14'($urandom % 16'h3F00),
                  14'($urandom % 16'h3F00), int'($urandom % 8),
                  1'($urandom % 2), 1 + int'($urandom % 6));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule